// File: doc/BRIEF.md
# Configurable PAL Output Macrocell Bank

This block is the output side of a small programmable-logic array. It holds a bank of eight macrocells. Each cell receives eight product terms from an external AND array, which is outside this block. From those terms each cell produces three things: a value for its pad, a tri-state enable for that pad, and a feedback bit that returns to the array. A configuration word chooses what each cell does. The word has two global bits, plus a mode bit and a polarity bit for every cell.

Each cell can work in one of five ways:
- a registered output, whose buffer follows a shared enable pin;
- a combinatorial I/O whose eighth term drives the buffer enable, in either a registered or a non-registered device;
- a dedicated combinatorial output that is always driven;
- a dedicated input, whose pad is never driven.

The feedback path takes one of four sources: the cell's own flip-flop, its own pad, or a neighbouring pad. The two end cells take the clock-pin level or the shared-enable pin instead of a neighbouring pad. That is how those two pins become array inputs in non-registered designs. Mode selection is combinational from the configuration inputs. A change takes effect at once, without waiting for a clock edge.

Top module: `pal_macrocell_bank`

## Requirements
- R1: Registered mode is globalCfg=2'b10 (bit0=0, bit1=1) with the cell's cellMode bit 0. On each rising clk edge the cell's flip-flop captures the polarity-adjusted OR of all eight of its terms. padOut and feedback both show the flip-flop output.
- R2: In registered mode, padOe equals sharedOe.
- R3: Combinatorial I/O mode is globalCfg=2'b10 or 2'b11 with cellMode 1. padOut is the polarity-adjusted OR of terms 0 to 6 only. padOe equals term 7. Term n of cell i is productTerms[i*8+n].
- R4: In combinatorial I/O mode, feedback is the cell's own padIn bit. The exception is globalCfg=2'b11, where the end cells take their edge source instead: cell 0 takes sharedOe and cell 7 takes clkPinLvl.
- R5: Dedicated output mode is globalCfg=2'b01 with cellMode 0. padOut is the polarity-adjusted OR of all eight terms and padOe is 1. Cells 3 and 4 give feedback 0. Every other cell gives its neighbour feedback, defined in R6.
- R6: Dedicated input mode is globalCfg=2'b01 with cellMode 1. padOe and padOut are 0. Feedback is the neighbour source: padIn[i-1] for cells 1 to 3, padIn[i+1] for cells 4 to 6, sharedOe for cell 0 and clkPinLvl for cell 7.
- R7: With cellPolarity 1, the result equals the OR of the terms. With cellPolarity 0, it is the inverse. This applies in front of the flip-flop as well as on the combinatorial paths.
- R8: Every other setting is illegal, that is globalCfg=2'b00, or globalCfg=2'b11 with cellMode 0. In an illegal cell, padOut, padOe and feedback are all 0.
- R9: While rst is high at a rising clk edge, every flip-flop clears to 0.
- R10: A change to globalCfg, cellMode or cellPolarity changes padOut, padOe and feedback with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous clear of the cell flip-flops |
| globalCfg | input | 2 | Global configuration bits |
| cellMode | input | 8 | Per-cell mode bit |
| cellPolarity | input | 8 | Per-cell polarity bit, 1 = active high |
| productTerms | input | 64 | Eight terms per cell, cell i at bits i*8+7..i*8 |
| clkPinLvl | input | 1 | Level of the clock pin, used as edge feedback |
| sharedOe | input | 1 | Shared output-enable pin, active high |
| padIn | input | 8 | Values read back from the pads |
| padOut | output | 8 | Value each cell drives toward its pad |
| padOe | output | 8 | Tri-state enable per pad |
| feedback | output | 8 | Feedback bit per cell to the array |

## Verification
The bound checker tests the enable rules on every cycle for every cell: the registered enable follows the pin, the term-7 enable applies in I/O modes, dedicated output is always on and dedicated input is always off. It also checks that illegal cells are silent and that the two middle cells have no feedback in dedicated output. On every cycle it compares the flip-flop capture with the previous cycle's terms, and after reset it checks that the flip-flops are clear. Neighbour and edge feedback routing, the polarity inversion and changes of configuration between clock edges can only be shown by the bench's scenarios. In those scenarios the bench sets up pad and pin patterns and then switches modes while the clock is low.

// File: rtl/pal_bank_pkg.sv
`timescale 1ns/1ps
package pal_bank_pkg;

  typedef enum logic [2:0] {
    MODE_REG,
    MODE_IO_REGDEV,
    MODE_DED_OUT,
    MODE_IO_NOREG,
    MODE_DED_IN,
    MODE_BAD
  } cellMode_e;

  typedef enum logic [1:0] {OE_OFF, OE_ON, OE_PIN, OE_TERM} oeSel_e;

  typedef enum logic [1:0] {FB_ZERO, FB_REG, FB_OWN_PAD, FB_NEIGHBOR} fbSel_e;

  // strobes handed from control to datapath, one per cell
  typedef struct packed {
    logic   sumAll;      // OR all terms (else drop the top term)
    logic   outFromReg;  // pad value comes from the flip-flop
    logic   outZero;     // force the pad value low
    oeSel_e oeSel;
    fbSel_e fbSel;
  } cellCtrl_t;

  function automatic cellMode_e decodeMode(input logic g0, input logic g1, input logic l0);
    case ({g0, g1, l0})
      3'b010:  return MODE_REG;
      3'b011:  return MODE_IO_REGDEV;
      3'b100:  return MODE_DED_OUT;
      3'b111:  return MODE_IO_NOREG;
      3'b101:  return MODE_DED_IN;
      default: return MODE_BAD;
    endcase
  endfunction

endpackage

// File: rtl/pal_bank_ctrl.sv
`timescale 1ns/1ps
module pal_bank_ctrl
  import pal_bank_pkg::*;
#(
  parameter int NUM_CELLS = 8
) (
  input  logic [1:0]                       globalCfg,
  input  logic [NUM_CELLS-1:0]             cellMode,
  output cellCtrl_t [NUM_CELLS-1:0]        ctrl
);

  localparam int HALF = NUM_CELLS / 2;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    localparam bit IS_EDGE = (i == 0) || (i == NUM_CELLS - 1);
    localparam bit IS_MID  = (i == HALF - 1) || (i == HALF);

    cellMode_e mode;
    logic      useNeighbor;
    cellCtrl_t c;

    assign mode = decodeMode(globalCfg[0], globalCfg[1], cellMode[i]);

    // end cells steer their feedback mux from bit 0, the others from bit 1
    if (IS_EDGE) begin : g_edgeSel
      assign useNeighbor = globalCfg[0];
    end else begin : g_midSel
      assign useNeighbor = ~globalCfg[1];
    end

    always_comb begin
      c            = '0;
      c.oeSel      = OE_OFF;
      c.fbSel      = FB_ZERO;
      case (mode)
        MODE_REG: begin
          c.sumAll     = 1'b1;
          c.outFromReg = 1'b1;
          c.oeSel      = OE_PIN;
        end
        MODE_IO_REGDEV, MODE_IO_NOREG: begin
          c.oeSel = OE_TERM;
        end
        MODE_DED_OUT: begin
          c.sumAll = 1'b1;
          c.oeSel  = OE_ON;
        end
        default: begin
          c.outZero = 1'b1;
        end
      endcase
      if (mode != MODE_BAD && !(mode == MODE_DED_OUT && IS_MID)) begin
        if (useNeighbor)            c.fbSel = FB_NEIGHBOR;
        else if (mode == MODE_REG)  c.fbSel = FB_REG;
        else                        c.fbSel = FB_OWN_PAD;
      end
    end

    assign ctrl[i] = c;
  end

endmodule

// File: rtl/pal_bank_datapath.sv
`timescale 1ns/1ps
module pal_bank_datapath
  import pal_bank_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int TERMS     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  cellCtrl_t [NUM_CELLS-1:0]      ctrl,
  input  logic [NUM_CELLS-1:0]           cellPolarity,
  input  logic [NUM_CELLS*TERMS-1:0]     productTerms,
  input  logic                           clkPinLvl,
  input  logic                           sharedOe,
  input  logic [NUM_CELLS-1:0]           padIn,
  output logic [NUM_CELLS-1:0]           padOut,
  output logic [NUM_CELLS-1:0]           padOe,
  output logic [NUM_CELLS-1:0]           feedback
);

  localparam int HALF    = NUM_CELLS / 2;
  localparam int TOP_IDX = TERMS - 1;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic [TERMS-1:0] terms;
    logic             orAll;
    logic             orLower;
    logic             sumSel;
    logic             polar;
    logic             regD;
    logic             regQ;
    logic             neighborVal;

    assign terms   = productTerms[i*TERMS +: TERMS];
    assign orAll   = |terms;
    assign orLower = |terms[TOP_IDX-1:0];
    assign sumSel  = ctrl[i].sumAll ? orAll : orLower;
    assign polar   = ~(sumSel ^ cellPolarity[i]);
    assign regD    = ~(orAll ^ cellPolarity[i]);

    always_ff @(posedge clk) begin
      if (rst) regQ <= 1'b0;
      else     regQ <= regD;
    end

    if (i == 0) begin : g_nbLow
      assign neighborVal = sharedOe;
    end else if (i == NUM_CELLS - 1) begin : g_nbHigh
      assign neighborVal = clkPinLvl;
    end else if (i < HALF) begin : g_nbDown
      assign neighborVal = padIn[i-1];
    end else begin : g_nbUp
      assign neighborVal = padIn[i+1];
    end

    always_comb begin
      if (ctrl[i].outZero)         padOut[i] = 1'b0;
      else if (ctrl[i].outFromReg) padOut[i] = regQ;
      else                         padOut[i] = polar;

      case (ctrl[i].oeSel)
        OE_ON:   padOe[i] = 1'b1;
        OE_PIN:  padOe[i] = sharedOe;
        OE_TERM: padOe[i] = terms[TOP_IDX];
        default: padOe[i] = 1'b0;
      endcase

      case (ctrl[i].fbSel)
        FB_REG:      feedback[i] = regQ;
        FB_OWN_PAD:  feedback[i] = padIn[i];
        FB_NEIGHBOR: feedback[i] = neighborVal;
        default:     feedback[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pal_macrocell_bank.sv
`timescale 1ns/1ps
module pal_macrocell_bank
  import pal_bank_pkg::*;
#(
  parameter int NUM_CELLS = 8,
  parameter int TERMS     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [1:0]                 globalCfg,
  input  logic [NUM_CELLS-1:0]       cellMode,
  input  logic [NUM_CELLS-1:0]       cellPolarity,
  input  logic [NUM_CELLS*TERMS-1:0] productTerms,
  input  logic                       clkPinLvl,
  input  logic                       sharedOe,
  input  logic [NUM_CELLS-1:0]       padIn,
  output logic [NUM_CELLS-1:0]       padOut,
  output logic [NUM_CELLS-1:0]       padOe,
  output logic [NUM_CELLS-1:0]       feedback
);

  cellCtrl_t [NUM_CELLS-1:0] ctrl;

  pal_bank_ctrl #(.NUM_CELLS(NUM_CELLS)) ctrl_i (
    .globalCfg (globalCfg),
    .cellMode  (cellMode),
    .ctrl      (ctrl)
  );

  pal_bank_datapath #(.NUM_CELLS(NUM_CELLS), .TERMS(TERMS)) dp_i (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .cellPolarity (cellPolarity),
    .productTerms (productTerms),
    .clkPinLvl    (clkPinLvl),
    .sharedOe     (sharedOe),
    .padIn        (padIn),
    .padOut       (padOut),
    .padOe        (padOe),
    .feedback     (feedback)
  );

endmodule

// File: rtl/pal_bank_chk.sv
`timescale 1ns/1ps
module pal_bank_chk #(
  parameter int NUM_CELLS = 8,
  parameter int TERMS     = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [1:0]                 globalCfg,
  input logic [NUM_CELLS-1:0]       cellMode,
  input logic [NUM_CELLS-1:0]       cellPolarity,
  input logic [NUM_CELLS*TERMS-1:0] productTerms,
  input logic                       sharedOe,
  input logic [NUM_CELLS-1:0]       padOut,
  input logic [NUM_CELLS-1:0]       padOe,
  input logic [NUM_CELLS-1:0]       feedback
);

  localparam int HALF = NUM_CELLS / 2;

  logic seenReset = 1'b0;
  always_ff @(posedge clk) if (rst) seenReset <= 1'b1;

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic isReg, isIo, isDedOut, isDedIn, isBad;
    assign isReg    = !globalCfg[0] &&  globalCfg[1] && !cellMode[i];
    assign isIo     =  globalCfg[1] &&  cellMode[i];
    assign isDedOut =  globalCfg[0] && !globalCfg[1] && !cellMode[i];
    assign isDedIn  =  globalCfg[0] && !globalCfg[1] &&  cellMode[i];
    assign isBad    = !(isReg || isIo || isDedOut || isDedIn);

    p_reg_capture_r1: assert property (@(posedge clk) disable iff (rst)
      (seenReset && !$past(rst) && isReg) |->
        padOut[i] == $past(~((|productTerms[i*TERMS +: TERMS]) ^ cellPolarity[i])));

    p_reg_oe_r2: assert property (@(posedge clk) disable iff (rst)
      isReg |-> padOe[i] == sharedOe);

    p_io_oe_r3: assert property (@(posedge clk) disable iff (rst)
      isIo |-> padOe[i] == productTerms[i*TERMS + TERMS - 1]);

    p_ded_out_oe_r5: assert property (@(posedge clk) disable iff (rst)
      isDedOut |-> padOe[i]);

    p_ded_in_off_r6: assert property (@(posedge clk) disable iff (rst)
      isDedIn |-> (!padOe[i] && !padOut[i]));

    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      isBad |-> (!padOe[i] && !padOut[i] && !feedback[i]));

    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
      (seenReset && $past(rst) && isReg) |-> !padOut[i]);

    if (i == HALF - 1 || i == HALF) begin : g_mid
      p_mid_no_fb_r5: assert property (@(posedge clk) disable iff (rst)
        isDedOut |-> !feedback[i]);
    end
  end

endmodule

bind pal_macrocell_bank pal_bank_chk #(.NUM_CELLS(NUM_CELLS), .TERMS(TERMS)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .globalCfg    (globalCfg),
  .cellMode     (cellMode),
  .cellPolarity (cellPolarity),
  .productTerms (productTerms),
  .sharedOe     (sharedOe),
  .padOut       (padOut),
  .padOe        (padOe),
  .feedback     (feedback)
);

// File: tb/pal_macrocell_bank_tb_top.sv
`timescale 1ns/1ps
module pal_macrocell_bank_tb_top;

  localparam int N = 8;
  localparam int T = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     globalCfg = 2'b00;
  logic [N-1:0]   cellMode = '0;
  logic [N-1:0]   cellPolarity = '0;
  logic [N*T-1:0] productTerms = '0;
  logic           clkPinLvl = 1'b0;
  logic           sharedOe = 1'b0;
  logic [N-1:0]   padIn = '0;
  logic [N-1:0]   padOut, padOe, feedback;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] qModel = '0;

  always #2 clk = ~clk;

  pal_macrocell_bank #(.NUM_CELLS(N), .TERMS(T)) dut_i (
    .clk(clk), .rst(rst), .globalCfg(globalCfg), .cellMode(cellMode),
    .cellPolarity(cellPolarity), .productTerms(productTerms),
    .clkPinLvl(clkPinLvl), .sharedOe(sharedOe), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .feedback(feedback)
  );

  // flip-flop model from R1/R7/R9
  always @(posedge clk) begin
    for (int i = 0; i < N; i++)
      qModel[i] <= rst ? 1'b0 : ~((|productTerms[i*T +: T]) ^ cellPolarity[i]);
  end

  function automatic logic pol(input logic v, input logic p);
    return p ? v : ~v;
  endfunction

  // returns {out, oe, fb}
  function automatic logic [2:0] expCell(input int i);
    logic [T-1:0] t;
    logic nb, o8, o7, p;
    t  = productTerms[i*T +: T];
    o8 = |t;
    o7 = |t[T-2:0];
    p  = cellPolarity[i];
    if (i == 0)          nb = sharedOe;
    else if (i == N-1)   nb = clkPinLvl;
    else if (i < N/2)    nb = padIn[i-1];
    else                 nb = padIn[i+1];
    case ({globalCfg[0], globalCfg[1], cellMode[i]})
      3'b010: return {qModel[i], sharedOe, qModel[i]};
      3'b011: return {pol(o7, p), t[T-1], padIn[i]};
      3'b100: return {pol(o8, p), 1'b1, (i == N/2-1 || i == N/2) ? 1'b0 : nb};
      3'b111: return {pol(o7, p), t[T-1], (i == 0 || i == N-1) ? nb : padIn[i]};
      3'b101: return {1'b0, 1'b0, nb};
      default: return 3'b000;
    endcase
  endfunction

  function automatic string tagFor(input int i);
    case ({globalCfg[0], globalCfg[1], cellMode[i]})
      3'b010:  return "R1";
      3'b011:  return "R3";
      3'b100:  return "R5";
      3'b111:  return "R4";
      3'b101:  return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic checkAll(input string tag);
    for (int i = 0; i < N; i++) begin
      logic [2:0] got, exp;
      string t;
      got = {padOut[i], padOe[i], feedback[i]};
      exp = expCell(i);
      t = (tag == "") ? tagFor(i) : tag;
      checks++;
      if (got !== exp) begin
        fails++;
        $display("FAIL %s cell %0d out/oe/fb actual=%b expected=%b", t, i, got, exp);
      end
    end
  endtask

  task automatic randomInputs();
    productTerms = {$urandom, $urandom};
    padIn        = N'($urandom);
    clkPinLvl    = 1'($urandom);
    sharedOe     = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'h1c0ffee5));
    globalCfg = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 checkAll("R9");                  // flip-flops clear after reset

    // R1: registered capture
    @(negedge clk);
    productTerms = 64'h0000_00ff_0000_0100; sharedOe = 1'b1; cellPolarity = 8'hA5;
    @(negedge clk);
    #1 checkAll("R1");
    // R2: enable follows the shared pin without a clock
    sharedOe = 1'b0;
    #1 checkAll("R2");
    sharedOe = 1'b1;
    #1 checkAll("R2");

    // R7: polarity on dedicated outputs
    @(negedge clk);
    globalCfg = 2'b01; cellMode = '0; productTerms = 64'h0100_0000_0080_0001; cellPolarity = 8'hFF;
    #1 checkAll("R7");
    cellPolarity = 8'h00;
    #1 checkAll("R7");

    // R5: middle cells silent, neighbours routed
    padIn = 8'hFF; sharedOe = 1'b1; clkPinLvl = 1'b1;
    #1 checkAll("R5");

    // R6: dedicated input routing
    cellMode = '1; padIn = 8'b0110_1001; sharedOe = 1'b0; clkPinLvl = 1'b1;
    #1 checkAll("R6");
    padIn = 8'b1001_0110; sharedOe = 1'b1; clkPinLvl = 1'b0;
    #1 checkAll("R6");

    // R8: illegal settings
    globalCfg = 2'b00; cellMode = 8'h3C;
    #1 checkAll("R8");
    globalCfg = 2'b11; cellMode = 8'h0F;
    #1 checkAll("R8");

    // R3: registered-device I/O with top term gating the buffer
    @(negedge clk);
    globalCfg = 2'b10; cellMode = '1; cellPolarity = 8'hF0;
    productTerms = 64'h8000_8080_0100_807F; padIn = 8'h5A;
    #1 checkAll("R3");

    // R4: non-registered I/O, end cells take the pins
    globalCfg = 2'b11; padIn = 8'h00; sharedOe = 1'b1; clkPinLvl = 1'b1;
    #1 checkAll("R4");
    sharedOe = 1'b0; clkPinLvl = 1'b0; padIn = 8'hFF;
    #1 checkAll("R4");

    // R10: configuration change between clock edges
    @(negedge clk);
    globalCfg = 2'b10; cellMode = '0; productTerms = {$urandom, $urandom};
    @(negedge clk);
    #1 checkAll("R10");
    globalCfg = 2'b01; cellPolarity = ~cellPolarity;
    #1 checkAll("R10");
    cellMode = 8'hAA;
    #1 checkAll("R10");

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      randomInputs();
      globalCfg    = 2'($urandom);
      cellMode     = N'($urandom);
      cellPolarity = N'($urandom);
      if (k % 50 == 17) rst = 1'b1;
      else              rst = 1'b0;
      #1 checkAll("");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule